// File: doc/BRIEF.md
# Redundant Digest Word Comparator

The block compares a 256-bit computed digest with a 256-bit expected digest, taking one 32-bit word per clock cycle after a single start pulse. When all eight words have been examined it raises a sticky done flag. Alongside done it presents a match result that is high only if every word was equal. Both digests must stay stable from the start pulse until done. Producing the digests is the job of other logic.

The block is built to resist fault injection. The word index is kept in two registers, one counting up and one holding the inverted count, and the two are compared every cycle. The control state machine uses a sparse six-bit encoding with a Hamming distance of at least three between legal states. The block also checks the index against the state: it must be zero while waiting and must sit on the last word once finished. A second start after reset is treated as a control-flow fault. Any fault drives the state machine into a terminal invalid state, which withholds done, and sets a fatal alert that only reset clears.

Top module: `digest_cmp`

## Requirements
- R1: After reset, done_o, match_o and alert_o are all 0.
- R2: Let the rising edge that samples start_i high in the waiting state be edge 0. done_o is 0 after edges 0 to 7, rises after edge 8, and then stays high while no fault occurs.
- R3: While done_o is high, match_o is 1 exactly when all eight 32-bit words are equal. Word i occupies bits [32*i+31:32*i] of each digest. While done_o is low, match_o is 0.
- R4: If the two copies of the word index disagree, alert_o is 1 after the next rising edge.
- R5: Once start_i has been sampled high, sampling start_i high again at any later edge before reset sets alert_o after that edge. This includes holding start_i high for two cycles and pulsing it after done.
- R6: While waiting for start, a word index other than 0 sets alert_o after the next edge.
- R7: In the done state, a word index other than 7 sets alert_o after the next edge.
- R8: An illegal state encoding, or any fault listed in R4 to R7, moves the state machine to a terminal invalid state. In that state alert_o is set, done_o is 0 from the next edge on, and a later start never produces done.
- R9: Once alert_o is 1, it stays 1 until rst_ni is asserted.
- R10: A single start pulse followed by a full comparison never raises alert_o, whether or not the digests match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, legal once per reset |
| calc_digest_i | input | 256 | Computed digest, word i at bits [32*i+31:32*i] |
| exp_digest_i | input | 256 | Expected digest, same word layout |
| done_o | output | 1 | Comparison finished |
| match_o | output | 1 | All words equal; valid only with done_o |
| alert_o | output | 1 | Sticky fatal alert |

## Verification
The counter and state checks in R4, R6, R7 and R8 cannot be reached through the ports, because a correct design never lets its index copies disagree or its state take an illegal code. The bench reaches them by briefly forcing internal registers to model a glitch. It forces a single index copy to model a pair mismatch, and it forces both copies to the same wrong index, in the waiting state and in the done state, to model a consistent but misplaced index. For the illegal state it forces a code outside the legal set. After each forced fault it checks alert_o and done_o at the ports. The main sweep flips a single bit in each word at several bit positions, so that every index value gets the chance to decide the result.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned NUM_WORDS = 8;

  // sparse encoding, pairwise Hamming distance >= 3
  typedef enum logic [5:0] {
    ST_WAIT = 6'b001011,
    ST_CMP  = 6'b110001,
    ST_DONE = 6'b101110,
    ST_BAD  = 6'b010100
  } dcmp_state_e;
endpackage

// File: rtl/digest_cmp_ctr.sv
module digest_cmp_ctr #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             incr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_a_q;
  logic [CNT_W-1:0] cnt_b_q;  // holds inverted count

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_a_q <= '0;
    else if (incr_i) cnt_a_q <= cnt_a_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_b_q <= '1;
    else if (incr_i) cnt_b_q <= cnt_b_q - 1'b1;
  end

  assign cnt_o = cnt_a_q;
  assign err_o = (cnt_a_q != ~cnt_b_q);
endmodule

// File: rtl/digest_cmp_sel.sv
module digest_cmp_sel #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic [NUM_WORDS*WORD_W-1:0] a_i,
  input  logic [NUM_WORDS*WORD_W-1:0] b_i,
  input  logic [IDX_W-1:0]            idx_i,
  output logic                        eq_o
);
  logic [NUM_WORDS-1:0] eq_vec;

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    assign eq_vec[i] = (a_i[i*WORD_W +: WORD_W] == b_i[i*WORD_W +: WORD_W]);
  end

  always_comb begin
    eq_o = 1'b0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (idx_i == IDX_W'(i)) eq_o = eq_vec[i];
    end
  end
endmodule

// File: rtl/digest_cmp_fsm.sv
module digest_cmp_fsm
  import dcmp_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 8,
  parameter int unsigned IDX_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] cnt_i,
  input  logic             fault_i,
  output logic             incr_o,
  output logic             acc_clr_o,
  output logic             acc_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  dcmp_state_e state_q, state_d;
  logic        seq_err;

  always_comb begin
    state_d   = state_q;
    incr_o    = 1'b0;
    acc_clr_o = 1'b0;
    acc_en_o  = 1'b0;
    seq_err   = 1'b0;
    unique case (state_q)
      ST_WAIT: begin
        if (cnt_i != '0) seq_err = 1'b1;
        if (start_i) begin
          state_d   = ST_CMP;
          acc_clr_o = 1'b1;
        end
      end
      ST_CMP: begin
        acc_en_o = 1'b1;
        if (start_i) seq_err = 1'b1;
        if (cnt_i == LAST) state_d = ST_DONE;
        else               incr_o  = 1'b1;
      end
      ST_DONE: begin
        if (start_i)       seq_err = 1'b1;
        if (cnt_i != LAST) seq_err = 1'b1;
      end
      ST_BAD: seq_err = 1'b1;
      default: seq_err = 1'b1;
    endcase
    if (seq_err || fault_i) begin
      state_d  = ST_BAD;
      incr_o   = 1'b0;
      acc_en_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WAIT;
    else         state_q <= state_d;
  end

  assign busy_o = (state_q != ST_WAIT);
  assign done_o = (state_q == ST_DONE);
  assign err_o  = seq_err;

  // R2: last word compared cleanly leads to done
  assert_cmp_to_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP && cnt_i == LAST && !start_i && !fault_i) |=> done_o);

  // R6: nonzero index while waiting drives the machine into the invalid state
  assert_wait_idx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && cnt_i != '0) |=> (state_q == ST_BAD));

  // R7: wrong index after completion drives the machine into the invalid state
  assert_done_idx_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DONE && cnt_i != LAST) |=> (state_q == ST_BAD));
endmodule

// File: rtl/digest_cmp.sv
module digest_cmp
  import dcmp_pkg::*;
#(
  parameter int unsigned WORD_W    = dcmp_pkg::WORD_W,
  parameter int unsigned NUM_WORDS = dcmp_pkg::NUM_WORDS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [NUM_WORDS*WORD_W-1:0] calc_digest_i,
  input  logic [NUM_WORDS*WORD_W-1:0] exp_digest_i,
  output logic                        done_o,
  output logic                        match_o,
  output logic                        alert_o
);
  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [IDX_W-1:0] idx;
  logic             ctr_err, fsm_err;
  logic             incr, acc_clr, acc_en, busy, word_eq;
  logic             acc_q, alert_q;

  digest_cmp_ctr #(.CNT_W(IDX_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .incr_i (incr),
    .cnt_o  (idx),
    .err_o  (ctr_err)
  );

  digest_cmp_sel #(
    .WORD_W    (WORD_W),
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W)
  ) u_sel (
    .a_i   (calc_digest_i),
    .b_i   (exp_digest_i),
    .idx_i (idx),
    .eq_o  (word_eq)
  );

  digest_cmp_fsm #(
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cnt_i     (idx),
    .fault_i   (ctr_err),
    .incr_o    (incr),
    .acc_clr_o (acc_clr),
    .acc_en_o  (acc_en),
    .busy_o    (busy),
    .done_o    (done_o),
    .err_o     (fsm_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= 1'b0;
    else if (acc_clr) acc_q <= 1'b1;
    else if (acc_en)  acc_q <= acc_q & word_eq;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alert_q <= 1'b0;
    else         alert_q <= alert_q | fsm_err | ctr_err;
  end

  assign match_o = done_o & acc_q;
  assign alert_o = alert_q;

  // R4: index copy mismatch raises the alert
  assert_ctr_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_err |=> alert_o);

  // R5: start after a comparison has begun raises the alert
  assert_second_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> alert_o);

  // R8: a fault withholds done
  assert_fault_no_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_err || ctr_err) |=> !done_o);

  // R9: alert is sticky
  assert_alert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alert_o |=> alert_o);
endmodule

// File: tb/digest_cmp_tb.sv
`timescale 1ns/1ps
module digest_cmp_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [255:0] calc_digest_i = '0;
  logic [255:0] exp_digest_i = '0;
  logic         done_o, match_o, alert_o;

  int nvec = 0;
  int nerr = 0;
  int cyc  = 0;

  always #2.5 clk_i = ~clk_i;

  digest_cmp u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .calc_digest_i (calc_digest_i),
    .exp_digest_i  (exp_digest_i),
    .done_o        (done_o),
    .match_o       (match_o),
    .alert_o       (alert_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nerr = nerr + 1;
      $display("FAIL watchdog: act=%0d cycles exp<=100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    nvec = nvec + 1;
    if (act !== exp) begin
      nerr = nerr + 1;
      $display("FAIL %s: act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    start_i = 1'b0;
    rst_ni  = 1'b0;
    @(negedge clk_i);
    rst_ni  = 1'b1;
  endtask

  // start sampled at the next edge (edge 0)
  task automatic pulse_start();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
  endtask

  task automatic run_cmp(input logic [255:0] a, input logic [255:0] b, input string tag);
    logic exp_m;
    exp_m = (a == b);
    calc_digest_i = a;
    exp_digest_i  = b;
    do_reset();
    pulse_start();
    repeat (7) @(negedge clk_i);
    chk({"R2 done low after edge 7 ", tag}, done_o, 1'b0);
    chk({"R3 match low before done ", tag}, match_o, 1'b0);
    @(negedge clk_i);
    chk({"R2 done after edge 8 ", tag}, done_o, 1'b1);
    chk({"R3 match ", tag}, match_o, exp_m);
    repeat (3) @(negedge clk_i);
    chk({"R2 done holds ", tag}, done_o, 1'b1);
    chk({"R10 no alert ", tag}, alert_o, 1'b0);
  endtask

  function automatic logic [255:0] pattern(input int k);
    logic [255:0] d;
    for (int i = 0; i < 8; i++)
      d[i*32 +: 32] = 32'(k) * 32'h9E3779B9 + 32'(i) * 32'h01000193 + 32'h5A5A0000;
    return d;
  endfunction

  initial begin
    logic [255:0] base;
    do_reset();
    @(negedge clk_i);
    chk("R1 done reset", done_o, 1'b0);
    chk("R1 match reset", match_o, 1'b0);
    chk("R1 alert reset", alert_o, 1'b0);

    // equal digests
    for (int k = 0; k < 4; k++) begin
      base = pattern(k);
      run_cmp(base, base, "equal");
    end
    run_cmp('0, '0, "zeros");
    run_cmp('1, '0, "ones vs zeros");

    // single-bit flip in each word at several positions
    for (int w = 0; w < 8; w++) begin
      for (int bsel = 0; bsel < 3; bsel++) begin
        int bp;
        bp = (bsel == 0) ? 0 : (bsel == 1) ? 17 : 31;
        base = pattern(w + 5);
        run_cmp(base, base ^ (256'd1 << (w*32 + bp)), "flip");
      end
    end

    // R5: second start mid-comparison
    calc_digest_i = pattern(1);
    exp_digest_i  = pattern(1);
    do_reset();
    pulse_start();
    repeat (3) @(negedge clk_i);
    chk("R5 no alert before restart", alert_o, 1'b0);
    pulse_start();
    chk("R5 alert on restart in compare", alert_o, 1'b1);
    repeat (10) @(negedge clk_i);
    chk("R8 no done after restart", done_o, 1'b0);
    chk("R9 alert sticky", alert_o, 1'b1);

    // R5: start held two cycles
    do_reset();
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i);
    chk("R5 no alert after first sample", alert_o, 1'b0);
    @(negedge clk_i) start_i = 1'b0;
    chk("R5 alert on held start", alert_o, 1'b1);

    // R5: start after done
    do_reset();
    pulse_start();
    repeat (9) @(negedge clk_i);
    chk("R5 done before restart", done_o, 1'b1);
    pulse_start();
    chk("R5 alert on restart after done", alert_o, 1'b1);
    chk("R8 done dropped", done_o, 1'b0);

    // R4: index copies disagree
    do_reset();
    @(negedge clk_i);
    force u_dut.u_ctr.cnt_b_q = 3'b010;
    @(negedge clk_i);
    release u_dut.u_ctr.cnt_b_q;
    chk("R4 alert on pair mismatch", alert_o, 1'b1);

    // R6: consistent nonzero index while waiting
    do_reset();
    @(negedge clk_i);
    force u_dut.u_ctr.cnt_a_q = 3'd3;
    force u_dut.u_ctr.cnt_b_q = 3'b100;
    @(negedge clk_i);
    release u_dut.u_ctr.cnt_a_q;
    release u_dut.u_ctr.cnt_b_q;
    chk("R6 alert on wait index", alert_o, 1'b1);

    // R7: consistent wrong index after done
    do_reset();
    pulse_start();
    repeat (9) @(negedge clk_i);
    chk("R7 done before fault", done_o, 1'b1);
    chk("R7 no alert before fault", alert_o, 1'b0);
    force u_dut.u_ctr.cnt_a_q = 3'd2;
    force u_dut.u_ctr.cnt_b_q = 3'b101;
    @(negedge clk_i);
    release u_dut.u_ctr.cnt_a_q;
    release u_dut.u_ctr.cnt_b_q;
    chk("R7 alert on done index", alert_o, 1'b1);
    chk("R7 done dropped", done_o, 1'b0);

    // R8: illegal state encoding
    do_reset();
    @(negedge clk_i);
    force u_dut.u_fsm.state_q = dcmp_pkg::dcmp_state_e'(6'b000000);
    @(negedge clk_i);
    release u_dut.u_fsm.state_q;
    chk("R8 alert on illegal state", alert_o, 1'b1);
    pulse_start();
    repeat (12) @(negedge clk_i);
    chk("R8 no done from invalid state", done_o, 1'b0);
    chk("R9 alert still set", alert_o, 1'b1);

    do_reset();
    @(negedge clk_i);
    chk("R9 reset clears alert", alert_o, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule